// File: doc/BRIEF.md
# System-Clock SPI Master

This block is a single-byte SPI master (mode 0) built entirely on one fast system clock. A divider counter inside the block produces the serial clock as an ordinary output. The moments at which data is shifted out and sampled are decoded from that count and used as clock enables. No flip-flop is ever clocked by the serial clock, so the design has no second clock domain and no crossing.

A host hands over one byte through a valid/ready write port. The block then performs the following sequence:

- It lowers chip select and waits a fixed lead-in time.
- It runs eight serial clock periods, MSB first, shifting out the byte and shifting in the slave's reply.
- It waits a trailing time and releases chip select.
- In the same cycle it presents the received byte with a one-cycle done strobe.

Back-pressure rules on the write port:

- A byte is taken only in a cycle where `wr_valid` and `wr_ready` are both high.
- `wr_ready` is low for the whole transfer and acts as the host's wait signal.
- A producer that raises `wr_valid` while `wr_ready` is low is simply not accepted, and the running transfer is untouched. A producer that keeps `wr_valid` high is accepted in the first cycle after the block returns to idle.
- The receive side has no ready signal. `rx_valid` is a one-cycle strobe, and `rx_data` holds its value until the next transfer completes.

Parameters are checked at elaboration: `RATIO` of at least 2, `LEAD_CLKS` and `TRAIL_CLKS` of at least 1, and `SAMPLE_DLY` below `RATIO`.

Top module: `spi_xfer_master`

## Requirements
- R1: A synchronous reset (`rst` high) returns the block to idle. In idle, `spi_cs_n` is 1, `spi_sclk` is 0, `wr_ready` is 1, `rx_valid` is 0 and `rx_data` is 0.
- R2: `wr_ready` is low from the cycle after an accepted write until the cycle `rx_valid` is high. A write offered while `wr_ready` is low starts nothing and does not change the bits shifted out or received.
- R3: `spi_cs_n` goes low in the cycle after acceptance. `spi_sclk` first goes high exactly `LEAD_CLKS` cycles later.
- R4: Each serial clock period lasts `RATIO` system clocks: high for `RATIO/2` (rounded down) cycles, then low for the rest. A transfer has exactly `DATA_W` periods. `spi_sclk` stays low whenever `spi_cs_n` is high.
- R5: `spi_mosi` carries `wr_data` MSB first. Bit 7 appears together with the falling chip select. Later bits change only in the cycle `spi_sclk` falls. `spi_mosi` keeps its last value (bit 0) while idle.
- R6: `spi_miso` is sampled `SAMPLE_DLY` system clocks after each cycle in which `spi_sclk` goes high: the value present in the cycle that lies `SAMPLE_DLY` cycles after the first high cycle is the one taken. The first sampled bit becomes bit 7 of `rx_data`.
- R7: `spi_cs_n` rises `LEAD_CLKS + DATA_W*RATIO + TRAIL_CLKS` cycles after the cycle in which it fell. `rx_valid` is high for exactly that one cycle, and `rx_data` then holds the received byte until the next transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Host offers a byte to send |
| wr_data | input | DATA_W | Byte to send, MSB first |
| wr_ready | output | 1 | High when idle; low means the host must wait |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| rx_valid | output | 1 | One-cycle strobe when the transfer completes |
| rx_data | output | DATA_W | Received byte, held until the next completion |

## Verification
Some properties are checked on every cycle:

- the serial clock stays low while chip select is high;
- the host is held off whenever chip select is low;
- an accepted write drops chip select on the next cycle;
- MOSI moves only together with a falling serial clock, and never while idle;
- the done strobe coincides with the release of chip select, lasts one cycle, and the received byte stays put between strobes.

Other behaviour needs the bench's scenarios:

- the exact lead and trail counts;
- the high and low phase lengths with an odd ratio;
- the bit order on MOSI;
- the delayed MISO sampling point. The bench drives MISO correctly only in the single cycle where the delayed sample must fall, so a sample taken in any other cycle returns the wrong byte.
- the claim that a write offered mid-transfer neither disturbs the running transfer nor starts another one.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } xfer_state_t;

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int RATIO      = 5,
  parameter int SAMPLE_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic fall_evt,
  output logic samp_evt,
  output logic wrap_evt
);
  localparam int CW   = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam int HALF = RATIO / 2;
  localparam logic [CW-1:0] C_LAST = CW'(RATIO - 1);
  localparam logic [CW-1:0] C_HALF = CW'(HALF);
  localparam logic [CW-1:0] C_HEND = CW'(HALF - 1);
  localparam logic [CW-1:0] C_SAMP = CW'(SAMPLE_DLY);

  logic [CW-1:0] cnt;

  // the count rests at zero while not running, so the first high phase is full length
  always_ff @(posedge clk) begin
    if (rst || !run)        cnt <= '0;
    else if (cnt == C_LAST) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  assign sclk     = run && (cnt < C_HALF);
  // edge at which the count leaves the high phase: serial clock falls here
  assign fall_evt = run && (cnt == C_HEND);
  assign samp_evt = run && (cnt == C_SAMP);
  assign wrap_evt = run && (cnt == C_LAST);
endmodule

// File: rtl/spi_seq.sv
module spi_seq
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LEAD_CLKS  = 3,
  parameter int TRAIL_CLKS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        wrap_evt,
  output xfer_state_t state,
  output logic        last_bit,
  output logic        done
);
  localparam int MAXP = (LEAD_CLKS > TRAIL_CLKS) ? LEAD_CLKS : TRAIL_CLKS;
  localparam int PCW  = $clog2(MAXP + 1);
  localparam int BW   = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [PCW-1:0] P_LEAD  = PCW'(LEAD_CLKS - 1);
  localparam logic [PCW-1:0] P_TRAIL = PCW'(TRAIL_CLKS - 1);
  localparam logic [BW-1:0]  B_LAST  = BW'(DATA_W - 1);

  logic [PCW-1:0] ph;
  logic [BW-1:0]  bidx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ph    <= '0;
      bidx  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_LEAD;
          ph    <= '0;
          bidx  <= '0;
        end
        ST_LEAD: begin
          if (ph == P_LEAD) begin
            state <= ST_SHIFT;
            ph    <= '0;
          end else ph <= ph + 1'b1;
        end
        ST_SHIFT: if (wrap_evt) begin
          if (bidx == B_LAST) begin
            state <= ST_TRAIL;
            ph    <= '0;
          end else bidx <= bidx + 1'b1;
        end
        default: begin
          if (ph == P_TRAIL) state <= ST_IDLE;
          else               ph    <= ph + 1'b1;
        end
      endcase
    end
  end

  assign last_bit = (bidx == B_LAST);
  assign done     = (state == ST_TRAIL) && (ph == P_TRAIL);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift_evt,
  input  logic              samp_evt,
  input  logic              miso,
  input  logic              done,
  output logic              mosi,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
      mosi  <= 1'b0;
    end else if (load) begin
      mosi  <= load_data[DATA_W-1];
      tx_sr <= {load_data[DATA_W-2:0], 1'b0};
    end else if (shift_evt) begin
      mosi  <= tx_sr[DATA_W-1];
      tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           rx_sr <= '0;
    else if (samp_evt) rx_sr <= {rx_sr[DATA_W-2:0], miso};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= done;
      if (done) rx_data <= rx_sr;
    end
  end
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int RATIO      = 5,
  parameter int LEAD_CLKS  = 3,
  parameter int TRAIL_CLKS = 2,
  parameter int SAMPLE_DLY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  generate
    if (RATIO < 2) begin : g_bad_ratio
      $error("RATIO must be at least 2");
    end
    if (LEAD_CLKS < 1 || TRAIL_CLKS < 1) begin : g_bad_guard
      $error("LEAD_CLKS and TRAIL_CLKS must be at least 1");
    end
    if (SAMPLE_DLY < 0 || SAMPLE_DLY >= RATIO) begin : g_bad_samp
      $error("SAMPLE_DLY must lie in 0 .. RATIO-1");
    end
    if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
    end
  endgenerate

  xfer_state_t state;
  logic start, run, last_bit, done;
  logic fall_evt, samp_evt, wrap_evt;

  assign wr_ready = (state == ST_IDLE);
  assign start    = wr_valid && wr_ready;
  assign run      = (state == ST_SHIFT);
  assign spi_cs_n = (state == ST_IDLE);

  spi_clk_div #(.RATIO(RATIO), .SAMPLE_DLY(SAMPLE_DLY)) u_div (
    .clk(clk), .rst(rst), .run(run), .sclk(spi_sclk),
    .fall_evt(fall_evt), .samp_evt(samp_evt), .wrap_evt(wrap_evt)
  );

  spi_seq #(.DATA_W(DATA_W), .LEAD_CLKS(LEAD_CLKS), .TRAIL_CLKS(TRAIL_CLKS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .wrap_evt(wrap_evt),
    .state(state), .last_bit(last_bit), .done(done)
  );

  spi_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk(clk), .rst(rst), .load(start), .load_data(wr_data),
    .shift_evt(fall_evt && !last_bit), .samp_evt(samp_evt), .miso(spi_miso),
    .done(done), .mosi(spi_mosi), .rx_valid(rx_valid), .rx_data(rx_data)
  );
endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              spi_cs_n,
  input logic              spi_sclk,
  input logic              spi_mosi,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data
);
  AST_SCLK_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk); // R4
  AST_HOLD_OFF_HOST: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> !wr_ready); // R2
  AST_ACCEPT_SELECTS: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> (!spi_cs_n && !wr_ready)); // R3
  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && $past(!spi_cs_n) && !$stable(spi_mosi)) |-> $fell(spi_sclk)); // R5
  AST_MOSI_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && $past(spi_cs_n)) |-> $stable(spi_mosi)); // R5
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $rose(spi_cs_n)); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R7
  AST_RX_HELD: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_data)); // R7
endmodule

bind spi_xfer_master spi_xfer_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
  .rx_valid(rx_valid), .rx_data(rx_data)
);

// File: tb/spi_xfer_master_tb.sv
module spi_xfer_master_tb;
  localparam int CLK_P  = 10;
  localparam int R      = 5;
  localparam int L      = 3;
  localparam int T      = 2;
  localparam int S      = 2;
  localparam int HALF   = R / 2;
  localparam int DONE_T = L + 8 * R + T + 1;
  localparam int NVEC   = 6;
  // each entry: {byte to send, byte the slave answers}
  localparam logic [15:0] VEC [NVEC] = '{
    16'hA53C, 16'h00FF, 16'hFF00, 16'h817E, 16'h5AC3, 16'h0180
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic spi_miso = 1'b0;
  logic wr_ready, spi_cs_n, spi_sclk, spi_mosi, rx_valid;
  logic [7:0] rx_data;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P / 2) clk = ~clk;

  spi_xfer_master #(.DATA_W(8), .RATIO(R), .LEAD_CLKS(L), .TRAIL_CLKS(T),
                    .SAMPLE_DLY(S)) u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rx_valid(rx_valid),
    .rx_data(rx_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_checks(input string tag);
    chk({tag, " R1 cs_n"}, int'(spi_cs_n), 1);
    chk({tag, " R1 sclk"}, int'(spi_sclk), 0);
    chk({tag, " R1 ready"}, int'(wr_ready), 1);
    chk({tag, " R1 rx_valid"}, int'(rx_valid), 0);
    chk({tag, " R1 rx_data"}, int'(rx_data), 0);
  endtask

  // one transfer with a slave model that presents each reply bit only in the
  // single cycle that lies S cycles after serial clock goes high
  task automatic xfer(input logic [7:0] tx, input logic [7:0] sl, input bit intrude);
    int k, rises, hi, first_hi, done_t, pulses, busy_bad, after_bad;
    logic [7:0] cap, got;
    logic prev;
    @(negedge clk);
    chk("R2 ready before write", int'(wr_ready), 1);
    wr_valid = 1'b1;
    wr_data  = tx;
    @(negedge clk);
    wr_valid = 1'b0;
    k = 0; rises = 0; hi = 0; first_hi = 0; done_t = 0; pulses = 0;
    busy_bad = 0; after_bad = 0; cap = '0; got = '0; prev = 1'b0;
    chk("R3 cs_n low after accept", int'(spi_cs_n), 0);
    chk("R5 mosi msb with select", int'(spi_mosi), int'(tx[7]));
    for (int t = 1; t <= DONE_T + 4; t++) begin
      if (spi_sclk && !prev) begin
        rises++;
        k = 0;
        cap = {cap[6:0], spi_mosi};
        if (first_hi == 0) first_hi = t;
      end else k++;
      if (spi_sclk) hi++;
      prev = spi_sclk;
      if (rises > 0 && rises <= 8) spi_miso = (k == S) ? sl[8-rises] : ~sl[8-rises];
      else spi_miso = 1'b0;
      if (rx_valid) begin
        pulses++;
        if (done_t == 0) done_t = t;
        got = rx_data;
      end
      if (t < DONE_T && wr_ready) busy_bad++;
      if (t >= DONE_T && (!spi_cs_n || spi_mosi != tx[0])) after_bad++;
      if (t > DONE_T && rx_data != sl) after_bad++;
      if (intrude && t == 10) begin
        wr_valid = 1'b1;
        wr_data  = ~tx;
      end else wr_valid = 1'b0;
      @(negedge clk);
    end
    chk("R3 lead cycles to first sclk high", first_hi, L + 1);
    chk("R4 sclk periods", rises, 8);
    chk("R4 sclk high cycles", hi, 8 * HALF);
    chk("R5 mosi bits msb first", int'(cap), int'(tx));
    chk("R6 delayed sample byte", int'(got), int'(sl));
    chk("R7 release cycle", done_t, DONE_T);
    chk("R7 single done strobe", pulses, 1);
    chk("R2 busy for whole transfer", busy_bad, 0);
    chk("R2 R5 R7 idle after done", after_bad, 0);
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    idle_checks("reset");
    rst = 1'b0;
    @(negedge clk);
    idle_checks("after reset");

    for (int i = 0; i < NVEC; i++) xfer(VEC[i][15:8], VEC[i][7:0], 1'b0);

    // write offered mid-transfer: ignored, current transfer intact (R2)
    xfer(8'hC6, 8'h39, 1'b1);

    // reset in the middle of a transfer returns to idle (R1)
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = 8'h77;
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_checks("mid-transfer reset");
    chk("R1 mosi cleared by reset", int'(spi_mosi), 0);

    // recovery after reset
    xfer(8'h96, 8'h69, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule